// File: doc/BRIEF.md
# UART Interrupt Source Combiner

This block gathers the interrupt causes of one serial channel (receive, error, transmit and modem) into a sticky source register. It drives a single interrupt line from the unmasked part of that register. The receive and transmit causes are level-driven by the FIFO fill counts, compared against trigger thresholds. Each threshold is a 3-bit software field multiplied by a factor that depends on which channel the instance serves. The error, modem, transmit-done and receive-timeout causes arrive as one-cycle event strobes from neighbouring logic.

Software clears causes by writing ones, either to the pending view or to the source register, and hides causes through a mask register. A side output tells the receive DMA engine that it has nothing to fetch. Baud-rate generation and the movement of data bytes happen elsewhere.

Top module: `uart_irq_combiner`

## Requirements
- R1: The source register holds receive in bit 0, error in bit 1, transmit in bit 2 and modem in bit 3. After reset the source register, the pending output, the mask and `irq` are all zero.
- R2: `pending` equals source AND NOT mask, and `irq` is high exactly when `pending` is nonzero.
- R3: With `fifoEnable` high, the transmit bit is set on the next clock whenever `txCount` is less than or equal to `txTrigField` times the channel factor. The factor is 32 for channel 0, 8 for channels 1 and 4, 2 for channels 2 and 3, and 0 for any other channel.
- R4: With `fifoEnable` high, the receive bit is set on the next clock whenever `rxCount` is at least (`rxTrigField` + 1) times the channel factor.
- R5: With `fifoEnable` high and `rxTimeoutEn` low, any nonzero `rxCount` sets the receive bit on the next clock, even below the threshold.
- R6: With `fifoEnable` low, the count comparisons have no effect. The receive bit is set on the next clock whenever `rxDataReady` is high.
- R7: A cycle with `pendWrEn` or `srcWrEn` high clears the source bits where `wrData` is 1. Bits where `wrData` is 0 are left unchanged. A bit whose set condition is active in the same cycle stays set.
- R8: The strobes `errEvt`, `txDoneEvt`, `modemEvt` and `rxTimeoutEvt` set the error, transmit, modem and receive source bits respectively on the next clock. The bits then stay set until they are cleared.
- R9: `dmaBusy` is high exactly when `rxDmaMode` equals 2'b10 and `rxCount` is zero.
- R10: A cycle with `maskWrEn` high loads `wrData` into the mask, and `pending` and `irq` reflect the new mask from the next clock on. The source register is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoEnable | input | 1 | FIFO mode enabled |
| txTrigField | input | 3 | Transmit trigger field |
| rxTrigField | input | 3 | Receive trigger field |
| rxTimeoutEn | input | 1 | Receive timeout enabled |
| rxDmaMode | input | 2 | Receive transfer mode, 2'b10 selects DMA |
| txCount | input | CNT_W | Transmit FIFO fill count |
| rxCount | input | CNT_W | Receive FIFO fill count |
| rxDataReady | input | 1 | Receive holding data valid (non-FIFO mode) |
| errEvt | input | 1 | Error event strobe |
| txDoneEvt | input | 1 | Transmit completion strobe |
| modemEvt | input | 1 | Modem event strobe |
| rxTimeoutEvt | input | 1 | Receive timeout strobe |
| srcWrEn | input | 1 | Write-ones-to-clear on source register |
| pendWrEn | input | 1 | Write-ones-to-clear on pending register |
| maskWrEn | input | 1 | Mask register load |
| wrData | input | 4 | Write data for the three register writes |
| source | output | 4 | Source register |
| pending | output | 4 | Unmasked pending causes |
| irq | output | 1 | Combined interrupt request |
| dmaBusy | output | 1 | Receive DMA has nothing to fetch |

## Verification
The bench runs the instance as channel 1, so a design that used the wrong channel factor would move the threshold edges off the counts the bench probes. It probes the exact threshold edges: the transmit count equal to the threshold and one above it, and the receive count one below and equal to the threshold. A comparison off by one, or a receive field without the +1, would set the bit one count early or late. It checks that a clear of a bit whose level condition is still active leaves that bit set, and that a zero write clears nothing. A clear that won over the set, or one applied to the wrong bit, would show up in `source`. It also checks that masking hides a cause from `irq` while `source` keeps it, and that FIFO counts are ignored in non-FIFO mode.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int SRC_W   = 4;
  localparam int FIELD_W = 3;
  localparam int RX_BIT  = 0;
  localparam int ERR_BIT = 1;
  localparam int TX_BIT  = 2;
  localparam int MDM_BIT = 3;

  typedef struct packed {
    logic [SRC_W-1:0] setBits;
    logic [SRC_W-1:0] clrBits;
    logic             maskLoad;
    logic [SRC_W-1:0] maskData;
  } irqStrobes_t;

  function automatic int trigFactor(input int ch);
    case (ch)
      0:       return 32;
      1, 4:    return 8;
      2, 3:    return 2;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_thresh.sv
module uart_irq_thresh
  import uart_irq_pkg::*;
#(
  parameter int CHANNEL = 0,
  parameter int CNT_W   = 8
) (
  input  logic               fifoEnable,
  input  logic [FIELD_W-1:0] txTrigField,
  input  logic [FIELD_W-1:0] rxTrigField,
  input  logic               rxTimeoutEn,
  input  logic [1:0]         rxDmaMode,
  input  logic [CNT_W-1:0]   txCount,
  input  logic [CNT_W-1:0]   rxCount,
  input  logic               rxDataReady,
  output logic               txLevel,
  output logic               rxLevel,
  output logic               dmaBusy
);
  localparam int FACTOR = trigFactor(CHANNEL);
  localparam int CMP_W  = CNT_W + FIELD_W + 7;

  logic [CMP_W-1:0] txThr;
  logic [CMP_W-1:0] rxThr;
  logic [CMP_W-1:0] txCntWide;
  logic [CMP_W-1:0] rxCntWide;

  generate
    if (FACTOR == 0) begin : g_noFactor
      assign txThr = '0;
      assign rxThr = '0;
    end else begin : g_factor
      assign txThr = CMP_W'(txTrigField) * CMP_W'(FACTOR);
      assign rxThr = (CMP_W'(rxTrigField) + CMP_W'(1)) * CMP_W'(FACTOR);
    end
  endgenerate

  assign txCntWide = CMP_W'(txCount);
  assign rxCntWide = CMP_W'(rxCount);

  always_comb begin
    txLevel = 1'b0;
    rxLevel = 1'b0;
    if (fifoEnable) begin
      txLevel = (txCntWide <= txThr);
      rxLevel = ((rxCount != '0) && !rxTimeoutEn) || (rxCntWide >= rxThr);
    end else begin
      rxLevel = rxDataReady;
    end
  end

  assign dmaBusy = (rxDmaMode == 2'b10) && (rxCount == '0);
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic             txLevel,
  input  logic             rxLevel,
  input  logic             errEvt,
  input  logic             txDoneEvt,
  input  logic             modemEvt,
  input  logic             rxTimeoutEvt,
  input  logic             srcWrEn,
  input  logic             pendWrEn,
  input  logic             maskWrEn,
  input  logic [SRC_W-1:0] wrData,
  output irqStrobes_t      strobes
);
  always_comb begin
    strobes                   = '0;
    strobes.setBits[RX_BIT]   = rxLevel | rxTimeoutEvt;
    strobes.setBits[ERR_BIT]  = errEvt;
    strobes.setBits[TX_BIT]   = txLevel | txDoneEvt;
    strobes.setBits[MDM_BIT]  = modemEvt;
    strobes.clrBits           = (srcWrEn | pendWrEn) ? wrData : '0;
    strobes.maskLoad          = maskWrEn;
    strobes.maskData          = wrData;
  end
endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  irqStrobes_t      strobes,
  output logic [SRC_W-1:0] source,
  output logic [SRC_W-1:0] pending,
  output logic             irq
);
  logic [SRC_W-1:0] srcQ;
  logic [SRC_W-1:0] maskQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ  <= '0;
      maskQ <= '0;
    end else begin
      srcQ <= (srcQ & ~strobes.clrBits) | strobes.setBits;
      if (strobes.maskLoad) maskQ <= strobes.maskData;
    end
  end

  assign source  = srcQ;
  assign pending = srcQ & ~maskQ;
  assign irq     = |pending;

  // R8
  src_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|strobes.setBits) |=> ((source & $past(strobes.setBits)) == $past(strobes.setBits)));

  // R7
  src_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|strobes.clrBits) |=> ((source & $past(strobes.clrBits & ~strobes.setBits)) == '0));

  // R7
  src_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((strobes.setBits == '0) && (strobes.clrBits == '0)) |=> $stable(source));

  // R10
  mask_hide_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.maskLoad |=> ((pending & $past(strobes.maskData)) == '0));
endmodule

// File: rtl/uart_irq_combiner.sv
module uart_irq_combiner
  import uart_irq_pkg::*;
#(
  parameter int CHANNEL = 0,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEnable,
  input  logic [2:0]       txTrigField,
  input  logic [2:0]       rxTrigField,
  input  logic             rxTimeoutEn,
  input  logic [1:0]       rxDmaMode,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  input  logic             rxDataReady,
  input  logic             errEvt,
  input  logic             txDoneEvt,
  input  logic             modemEvt,
  input  logic             rxTimeoutEvt,
  input  logic             srcWrEn,
  input  logic             pendWrEn,
  input  logic             maskWrEn,
  input  logic [3:0]       wrData,
  output logic [3:0]       source,
  output logic [3:0]       pending,
  output logic             irq,
  output logic             dmaBusy
);
  logic        txLevel;
  logic        rxLevel;
  irqStrobes_t strobes;

  uart_irq_thresh #(.CHANNEL(CHANNEL), .CNT_W(CNT_W)) thresh_i (
    .fifoEnable (fifoEnable),
    .txTrigField(txTrigField),
    .rxTrigField(rxTrigField),
    .rxTimeoutEn(rxTimeoutEn),
    .rxDmaMode  (rxDmaMode),
    .txCount    (txCount),
    .rxCount    (rxCount),
    .rxDataReady(rxDataReady),
    .txLevel    (txLevel),
    .rxLevel    (rxLevel),
    .dmaBusy    (dmaBusy)
  );

  uart_irq_ctrl ctrl_i (
    .txLevel     (txLevel),
    .rxLevel     (rxLevel),
    .errEvt      (errEvt),
    .txDoneEvt   (txDoneEvt),
    .modemEvt    (modemEvt),
    .rxTimeoutEvt(rxTimeoutEvt),
    .srcWrEn     (srcWrEn),
    .pendWrEn    (pendWrEn),
    .maskWrEn    (maskWrEn),
    .wrData      (wrData),
    .strobes     (strobes)
  );

  uart_irq_dp dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .source (source),
    .pending(pending),
    .irq    (irq)
  );
endmodule

// File: tb/uart_irq_combiner_tb_top.sv
module uart_irq_combiner_tb_top;
  localparam int CH    = 1;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rstN;
  logic fifoEnable, rxTimeoutEn, rxDataReady;
  logic [2:0] txTrigField, rxTrigField;
  logic [1:0] rxDmaMode;
  logic [CNT_W-1:0] txCount, rxCount;
  logic errEvt, txDoneEvt, modemEvt, rxTimeoutEvt;
  logic srcWrEn, pendWrEn, maskWrEn;
  logic [3:0] wrData;
  logic [3:0] source, pending;
  logic irq, dmaBusy;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  uart_irq_combiner #(.CHANNEL(CH), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .fifoEnable(fifoEnable), .txTrigField(txTrigField),
    .rxTrigField(rxTrigField), .rxTimeoutEn(rxTimeoutEn), .rxDmaMode(rxDmaMode),
    .txCount(txCount), .rxCount(rxCount), .rxDataReady(rxDataReady),
    .errEvt(errEvt), .txDoneEvt(txDoneEvt), .modemEvt(modemEvt),
    .rxTimeoutEvt(rxTimeoutEvt), .srcWrEn(srcWrEn), .pendWrEn(pendWrEn),
    .maskWrEn(maskWrEn), .wrData(wrData), .source(source), .pending(pending),
    .irq(irq), .dmaBusy(dmaBusy)
  );

  function automatic int expFactor(input int ch);
    if (ch == 0) return 32;
    if (ch == 1 || ch == 4) return 8;
    if (ch == 2 || ch == 3) return 2;
    return 0;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    fifoEnable = 1; txTrigField = 0; rxTrigField = 0; rxTimeoutEn = 1;
    txCount = 5; rxCount = 0; rxDataReady = 0; rxDmaMode = 0;
    errEvt = 0; txDoneEvt = 0; modemEvt = 0; rxTimeoutEvt = 0;
    srcWrEn = 1; pendWrEn = 0; maskWrEn = 1; wrData = 4'hF;
    step();
    srcWrEn = 0; maskWrEn = 0; wrData = 0;
    maskWrEn = 1; step(); maskWrEn = 0;
  endtask

  task automatic t_reset();
    check("R1 reset source", source, 0);
    check("R1 reset pending", pending, 0);
    check("R1 reset irq", irq, 0);
  endtask

  task automatic t_txThreshold();
    int thr;
    quiet();
    txTrigField = 2;
    thr = 2 * expFactor(CH);
    txCount = CNT_W'(thr + 1);
    step(); step();
    check("R3 tx above threshold", source, 0);
    txCount = CNT_W'(thr);
    step();
    check("R3 tx at threshold", source, 4);
    check("R2 pending tx", pending, 4);
    check("R2 irq tx", irq, 1);
  endtask

  task automatic t_rxThreshold();
    int thr;
    quiet();
    rxTrigField = 1;
    thr = 2 * expFactor(CH);
    rxCount = CNT_W'(thr - 1);
    step(); step();
    check("R4 rx below threshold", source, 0);
    rxCount = CNT_W'(thr);
    step();
    check("R4 rx at threshold", source, 1);
  endtask

  task automatic t_rxAnyData();
    quiet();
    rxTrigField = 3;
    rxTimeoutEn = 0;
    rxCount = 1;
    step();
    check("R5 rx data without timeout", source, 1);
  endtask

  task automatic t_fifoOff();
    quiet();
    fifoEnable = 0; txCount = 0; rxCount = 20; rxTimeoutEn = 0;
    step(); step();
    check("R6 counts ignored in non-fifo mode", source, 0);
    rxDataReady = 1;
    step();
    check("R6 data ready sets rx", source, 1);
  endtask

  task automatic t_mask();
    quiet();
    errEvt = 1; step(); errEvt = 0; step();
    check("R8 error event", source, 2);
    check("R2 pending error", pending, 2);
    maskWrEn = 1; wrData = 4'h2;
    step();
    maskWrEn = 0; wrData = 0;
    check("R10 masked pending", pending, 0);
    check("R10 masked irq", irq, 0);
    check("R10 source kept under mask", source, 2);
    maskWrEn = 1; step(); maskWrEn = 0;
    check("R10 unmasked pending", pending, 2);
  endtask

  task automatic t_clear();
    quiet();
    errEvt = 1; modemEvt = 1; step(); errEvt = 0; modemEvt = 0;
    check("R8 modem and error", source, 4'hA);
    pendWrEn = 1; wrData = 4'h2; step(); pendWrEn = 0;
    check("R7 pending write clears source", source, 4'h8);
    srcWrEn = 1; wrData = 4'h8; step(); srcWrEn = 0;
    check("R7 source write clears", source, 0);
    errEvt = 1; step(); errEvt = 0;
    pendWrEn = 1; wrData = 4'h0; step(); pendWrEn = 0;
    check("R7 zero write no effect", source, 2);
    srcWrEn = 1; wrData = 4'h2; step(); srcWrEn = 0;
    txCount = 0; step();
    check("R3 tx empty sets", source, 4);
    srcWrEn = 1; wrData = 4'h4; step(); srcWrEn = 0;
    check("R7 active level wins over clear", source, 4);
  endtask

  task automatic t_events();
    quiet();
    txDoneEvt = 1; step(); txDoneEvt = 0; step();
    check("R8 tx done event sticky", source, 4);
    rxTimeoutEvt = 1; step(); rxTimeoutEvt = 0;
    check("R8 rx timeout event", source, 5);
  endtask

  task automatic t_dma();
    quiet();
    rxDmaMode = 2'b10; rxCount = 0; #1;
    check("R9 dma busy empty", dmaBusy, 1);
    rxCount = 3; #1;
    check("R9 dma not busy with data", dmaBusy, 0);
    rxDmaMode = 2'b01; rxCount = 0; #1;
    check("R9 dma not busy other mode", dmaBusy, 0);
  endtask

  initial begin
    rstN = 0;
    fifoEnable = 0; txTrigField = 0; rxTrigField = 0; rxTimeoutEn = 1;
    txCount = 5; rxCount = 0; rxDataReady = 0; rxDmaMode = 0;
    errEvt = 0; txDoneEvt = 0; modemEvt = 0; rxTimeoutEvt = 0;
    srcWrEn = 0; pendWrEn = 0; maskWrEn = 0; wrData = 0;
    step(); step();
    rstN = 1;
    t_reset();
    t_txThreshold();
    t_rxThreshold();
    t_rxAnyData();
    t_fifoOff();
    t_mask();
    t_clear();
    t_events();
    t_dma();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule